// File: doc/BRIEF.md
# Adaptive Temporal-Spatial Colour Depth Reducer

This block sits in a display pixel path and turns 24-bit RGB (8 bits per channel) into 18-bit RGB (6 bits per channel) for a panel of lower depth. Each channel is first widened to a 9-bit working value. The three low bits of that value then decide how many of eight pixel-frame slots receive a +1 on the truncated 6-bit level. The slots are formed by a 2x2 spatial group and a frame phase, so the average the panel shows over time and space tracks the 8-bit input.

The pattern is picked per pixel and per channel. Four algorithm classes exist. The default class is dithered. A fully black pixel, a fully white pixel, and a single channel that sits at its minimum or maximum code are never dithered. Pixel position and frame phase come from the incoming timing signals. In sync mode, frames start on the active VS edge and lines on the active HS edge. In DE-only mode, rows follow the falling edge of active DE, and a frame starts when DE stays inactive longer than a programmed line time. Each control input has its own polarity bit.

When dithering is disabled, the 8-bit data passes through unchanged. Both paths have a single register stage, and the control outputs are delayed to match.

Top module: `frc_dither_top`

## Requirements
- R1: While reset is high at a clock edge, every output register is cleared to zero.
- R2: Outputs are registered with a latency of exactly one clock: the pixel and the raw hs/vs/de pins presented at edge N appear at the outputs after edge N.
- R3: With cfg_enable low, each output channel equals its input channel on all 8 bits.
- R4: With cfg_enable high, output bits [1:0] of every channel are zero, and bits [7:2] equal either in[7:2] or in[7:2]+1.
- R5: The working value is {in[7:0], in[7]}. Its low three bits give k = {in[1:0], in[7]}. The position code is p = {row[0]^col[0], row[0]}, where col is the pixel index within the active line and row is the line index within the frame, both starting at 0. With f the frame phase (frame count mod 8), the slot rank is ((p + f[1:0]) mod 4)*2 + f[2]. For a default-class channel, +1 is applied exactly when rank < k.
- R6: The incremented level saturates at 63, so inputs 252 to 255 always give 8'hFC.
- R7: A channel at code 0 or 255 is never dithered. Every slot outputs 0 or 8'hFC for it. The same holds for every channel of an all-black or all-white pixel.
- R8: For every input code c, over 8 consecutive frames of a 2x2 region, four times the mean output level is within 1 of min(c, 252).
- R9: In sync mode (cfg_de_only=0), an active-going VS edge starts a new frame (frame count +1, row 0). An active-going HS edge advances the row. The column counts active DE cycles and resets when DE is inactive.
- R10: In DE-only mode, HS and VS are ignored and the row advances on the active-to-inactive DE edge. A frame starts on the (cfg_line_time+1)-th consecutive inactive DE cycle, so a gap of exactly cfg_line_time cycles does not start a frame.
- R11: Each of hs, vs and de is active high when its polarity bit is 1 and active low when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | 1 = reduce and dither, 0 = pass through |
| cfg_de_only | input | 1 | 1 = DE-only timing, 0 = sync (HS/VS) timing |
| cfg_hs_pol | input | 1 | HS active level |
| cfg_vs_pol | input | 1 | VS active level |
| cfg_de_pol | input | 1 | DE active level |
| cfg_line_time | input | IDLE_W | Inactive-DE cycles that still count as a line gap |
| hs_in | input | 1 | Horizontal sync pin |
| vs_in | input | 1 | Vertical sync pin |
| de_in | input | 1 | Data enable pin |
| r_in | input | PIX_W | Red input |
| g_in | input | PIX_W | Green input |
| b_in | input | PIX_W | Blue input |
| hs_out | output | 1 | hs_in delayed one clock |
| vs_out | output | 1 | vs_in delayed one clock |
| de_out | output | 1 | de_in delayed one clock |
| r_out | output | PIX_W | Red output |
| g_out | output | PIX_W | Green output |
| b_out | output | PIX_W | Blue output |

## Verification
The bench uses the default parameters: 8-bit channels reduced to 6, 4-bit frame counter, 12-bit row and column counters, and a 16-bit idle counter with cfg_line_time set to 10. With these values, all 256 codes can be swept through eight full frames of a 2x2 active area in sync mode, which exercises every slot rank, the saturation codes 252 to 254 and both extreme codes. The short line time also makes DE-only framing cheap to reach, including a line gap of exactly the threshold that must not start a frame.

// File: rtl/frc_pkg.sv
package frc_pkg;
  // dithering algorithm class chosen per channel
  typedef enum logic [1:0] {
    ALG_DEFAULT   = 2'd0,
    ALG_BLACK_PIX = 2'd1,
    ALG_WHITE_PIX = 2'd2,
    ALG_FULL_SUB  = 2'd3
  } frc_alg_e;

  // slot rank: 2x2 spatial position (2 bits) plus one temporal bit
  localparam int RANK_W = 3;
endpackage

// File: rtl/frc_timing.sv
module frc_timing #(
  parameter int COL_W   = 12,
  parameter int ROW_W   = 12,
  parameter int FRAME_W = 4,
  parameter int IDLE_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_de_only,
  input  logic                      cfg_hs_pol,
  input  logic                      cfg_vs_pol,
  input  logic                      cfg_de_pol,
  input  logic [IDLE_W-1:0]         cfg_line_time,
  input  logic                      hs_in,
  input  logic                      vs_in,
  input  logic                      de_in,
  output logic [frc_pkg::RANK_W-1:0] slot_rank
);
  localparam int PH_W = 3;

  logic hs_a, vs_a, de_a;
  logic hs_q, vs_q, de_q;
  logic [COL_W-1:0]   col_cnt;
  logic [ROW_W-1:0]   row_cnt;
  logic [FRAME_W-1:0] frame_cnt;
  logic [IDLE_W-1:0]  idle_cnt;
  logic frame_start, row_adv, idle_hit;
  logic [1:0] pos_code;
  logic [PH_W-1:0] phase;

  // normalise polarity: pol=1 means active high
  assign hs_a = ~(hs_in ^ cfg_hs_pol);
  assign vs_a = ~(vs_in ^ cfg_vs_pol);
  assign de_a = ~(de_in ^ cfg_de_pol);

  assign idle_hit    = ~de_a && (idle_cnt == cfg_line_time);
  assign frame_start = cfg_de_only ? idle_hit : (vs_a & ~vs_q);
  assign row_adv     = cfg_de_only ? (de_q & ~de_a) : (hs_a & ~hs_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q      <= 1'b0;
      vs_q      <= 1'b0;
      de_q      <= 1'b0;
      col_cnt   <= '0;
      row_cnt   <= '0;
      frame_cnt <= '0;
      idle_cnt  <= '0;
    end else begin
      hs_q <= hs_a;
      vs_q <= vs_a;
      de_q <= de_a;
      col_cnt <= de_a ? col_cnt + 1'b1 : '0;
      if (de_a)
        idle_cnt <= '0;
      else if (idle_cnt != '1)
        idle_cnt <= idle_cnt + 1'b1;
      if (frame_start) begin
        frame_cnt <= frame_cnt + 1'b1;
        row_cnt   <= '0;
      end else if (row_adv) begin
        row_cnt <= row_cnt + 1'b1;
      end
    end
  end

  // ordered 2x2 code: (0,0)=0 (1,1)=1 (0,1)=2 (1,0)=3, rotated per frame
  assign pos_code  = {row_cnt[0] ^ col_cnt[0], row_cnt[0]};
  assign phase     = frame_cnt[PH_W-1:0];
  assign slot_rank = {pos_code + phase[1:0], phase[2]};
endmodule

// File: rtl/frc_chan.sv
module frc_chan #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  frc_pkg::frc_alg_e          alg,
  input  logic [IN_W-1:0]            pix,
  input  logic [frc_pkg::RANK_W-1:0] rank,
  output logic [IN_W-1:0]            pix_q
);
  localparam int TR_W  = IN_W - OUT_W;
  localparam int EXP_W = IN_W + 1;
  localparam int K_W   = TR_W + 1;

  logic [EXP_W-1:0] wide;
  logic [OUT_W-1:0] top;
  logic [K_W-1:0]   frac;
  logic             bump;
  logic [OUT_W-1:0] lvl;
  logic [IN_W-1:0]  nxt;

  assign wide = {pix, pix[IN_W-1]};
  assign top  = wide[EXP_W-1 -: OUT_W];
  assign frac = wide[K_W-1:0];
  assign bump = (alg == frc_pkg::ALG_DEFAULT) && (frac > rank) && (top != '1);
  assign lvl  = top + {{(OUT_W-1){1'b0}}, bump};
  assign nxt  = en ? {lvl, {TR_W{1'b0}}} : pix;

  always_ff @(posedge clk) begin
    if (rst) pix_q <= '0;
    else     pix_q <= nxt;
  end
endmodule

// File: rtl/frc_dither_top.sv
module frc_dither_top #(
  parameter int PIX_W   = 8,
  parameter int OUT_W   = 6,
  parameter int COL_W   = 12,
  parameter int ROW_W   = 12,
  parameter int FRAME_W = 4,
  parameter int IDLE_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_de_only,
  input  logic              cfg_hs_pol,
  input  logic              cfg_vs_pol,
  input  logic              cfg_de_pol,
  input  logic [IDLE_W-1:0] cfg_line_time,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              de_in,
  input  logic [PIX_W-1:0]  r_in,
  input  logic [PIX_W-1:0]  g_in,
  input  logic [PIX_W-1:0]  b_in,
  output logic              hs_out,
  output logic              vs_out,
  output logic              de_out,
  output logic [PIX_W-1:0]  r_out,
  output logic [PIX_W-1:0]  g_out,
  output logic [PIX_W-1:0]  b_out
);
  localparam int NCH = 3;

  logic [frc_pkg::RANK_W-1:0] rank;
  logic [PIX_W-1:0] ch_in  [NCH];
  logic [PIX_W-1:0] ch_out [NCH];
  logic pix_black, pix_white;

  frc_timing #(
    .COL_W(COL_W), .ROW_W(ROW_W), .FRAME_W(FRAME_W), .IDLE_W(IDLE_W)
  ) u_timing (
    .clk(clk), .rst(rst),
    .cfg_de_only(cfg_de_only), .cfg_hs_pol(cfg_hs_pol),
    .cfg_vs_pol(cfg_vs_pol), .cfg_de_pol(cfg_de_pol),
    .cfg_line_time(cfg_line_time),
    .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .slot_rank(rank)
  );

  assign ch_in[0] = r_in;
  assign ch_in[1] = g_in;
  assign ch_in[2] = b_in;
  assign pix_black = (r_in == '0) && (g_in == '0) && (b_in == '0);
  assign pix_white = (r_in == '1) && (g_in == '1) && (b_in == '1);

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    frc_pkg::frc_alg_e alg;
    always_comb begin
      if (pix_black)                               alg = frc_pkg::ALG_BLACK_PIX;
      else if (pix_white)                          alg = frc_pkg::ALG_WHITE_PIX;
      else if (ch_in[gi] == '0 || ch_in[gi] == '1) alg = frc_pkg::ALG_FULL_SUB;
      else                                         alg = frc_pkg::ALG_DEFAULT;
    end
    frc_chan #(.IN_W(PIX_W), .OUT_W(OUT_W)) u_chan (
      .clk(clk), .rst(rst), .en(cfg_enable), .alg(alg),
      .pix(ch_in[gi]), .rank(rank), .pix_q(ch_out[gi])
    );
  end

  assign r_out = ch_out[0];
  assign g_out = ch_out[1];
  assign b_out = ch_out[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_out <= 1'b0;
      vs_out <= 1'b0;
      de_out <= 1'b0;
    end else begin
      hs_out <= hs_in;
      vs_out <= vs_in;
      de_out <= de_in;
    end
  end
endmodule

// File: rtl/frc_dither_chk.sv
module frc_dither_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_enable,
  input logic         de_in,
  input logic [W-1:0] r_in,
  input logic [W-1:0] g_in,
  input logic         de_out,
  input logic [W-1:0] r_out,
  input logic [W-1:0] g_out
);
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    primed |-> de_out == $past(de_in));

  p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(cfg_enable) |-> r_out == $past(r_in));

  p_low_zero_r4: assert property (@(posedge clk) disable iff (rst)
    primed && $past(cfg_enable) |-> r_out[1:0] == 2'b00 && g_out[1:0] == 2'b00);

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    primed && $past(cfg_enable) |->
      (r_out[W-1:2] == $past(r_in[W-1:2])) ||
      (r_out[W-1:2] == $past(r_in[W-1:2]) + 1'b1));

  p_saturate_r6: assert property (@(posedge clk) disable iff (rst)
    primed && $past(cfg_enable) && $past(r_in[W-1:2]) == '1 |-> r_out[W-1:2] == '1);

  p_black_r7: assert property (@(posedge clk) disable iff (rst)
    primed && $past(cfg_enable) && $past(r_in) == '0 |-> r_out == '0);

  p_white_r7: assert property (@(posedge clk) disable iff (rst)
    primed && $past(cfg_enable) && $past(r_in) == '1 |-> r_out == {{(W-2){1'b1}}, 2'b00});
endmodule

bind frc_dither_top frc_dither_chk #(.W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .de_in(de_in),
  .r_in(r_in), .g_in(g_in), .de_out(de_out), .r_out(r_out), .g_out(g_out)
);

// File: tb/frc_dither_top_tb.sv
module frc_dither_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 1'b0, cfg_de_only = 1'b0;
  logic cfg_hs_pol = 1'b1, cfg_vs_pol = 1'b1, cfg_de_pol = 1'b1;
  logic [15:0] cfg_line_time = 16'd10;
  logic hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
  logic [7:0] r_in = '0, g_in = '0, b_in = '0;
  logic hs_out, vs_out, de_out;
  logic [7:0] r_out, g_out, b_out;

  int n_chk = 0, n_fail = 0;
  int fr = 0, row = 0, col = 0;
  bit acc_on = 0;
  int sum_r = 0, sum_g = 0, min_r = 0, max_r = 0;

  always #2 clk = ~clk;

  frc_dither_top u_dut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_de_only(cfg_de_only),
    .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol), .cfg_de_pol(cfg_de_pol),
    .cfg_line_time(cfg_line_time), .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .r_in(r_in), .g_in(g_in), .b_in(b_in), .hs_out(hs_out), .vs_out(vs_out),
    .de_out(de_out), .r_out(r_out), .g_out(g_out), .b_out(b_out)
  );

  function automatic logic [7:0] exp_ch(input logic [7:0] c, input bit e,
                                        input int ph, input int rw, input int cl);
    int top, k, p, rank, v;
    if (!e) return c;
    top = int'(c) / 4;
    k = (int'(c) % 4) * 2 + int'(c[7]);
    if (c == 8'd0 || c == 8'd255) return 8'(top * 4);
    p = (((rw ^ cl) & 1) * 2) + (rw & 1);
    rank = (((p + ph) & 3) * 2) + ((ph >> 2) & 1);
    v = top + ((rank < k) ? 1 : 0);
    if (v > 63) v = 63;
    return 8'(v * 4);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample 1 ns after the next posedge
  task automatic cyc(input bit hs_a, input bit vs_a, input bit de_a,
                     input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                     input bit chk, input string tag);
    logic [7:0] er, eg, eb;
    logic ph_hs, ph_vs, ph_de;
    @(negedge clk);
    ph_hs = cfg_hs_pol ? hs_a : ~hs_a;
    ph_vs = cfg_vs_pol ? vs_a : ~vs_a;
    ph_de = cfg_de_pol ? de_a : ~de_a;
    hs_in = ph_hs; vs_in = ph_vs; de_in = ph_de;
    r_in = r; g_in = g; b_in = b;
    er = exp_ch(r, cfg_enable, fr & 7, row, col);
    eg = exp_ch(g, cfg_enable, fr & 7, row, col);
    eb = exp_ch(b, cfg_enable, fr & 7, row, col);
    @(posedge clk); #1;
    if (chk) begin
      check({tag, " red"}, r_out, er);
      check({tag, " green"}, g_out, eg);
      check({tag, " blue"}, b_out, eb);
      check("R2 control delay", {hs_out, vs_out, de_out}, {ph_hs, ph_vs, ph_de});
      if (cfg_enable) check("R4 low bits", {r_out[1:0], g_out[1:0], b_out[1:0]}, 0);
      if (cfg_enable && r >= 8'd252) check("R6 saturation", r_out, 8'hFC);
      if (acc_on) begin
        sum_r += int'(r_out[7:2]);
        sum_g += int'(g_out[7:2]);
        if (int'(r_out) < min_r) min_r = int'(r_out);
        if (int'(r_out) > max_r) max_r = int'(r_out);
      end
    end
    col = de_a ? col + 1 : 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    hs_in = ~cfg_hs_pol; vs_in = ~cfg_vs_pol; de_in = ~cfg_de_pol;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    fr = 0; row = 0; col = 0;
  endtask

  task automatic sync_frame(input logic [7:0] cr, input logic [7:0] cg);
    cyc(0, 1, 0, 8'd0, 8'd0, 8'd0, 0, "");
    fr++; row = 0;
    cyc(0, 0, 0, 8'd0, 8'd0, 8'd0, 0, "");
    for (int l = 0; l < 2; l++) begin
      for (int p = 0; p < 2; p++)
        cyc(0, 0, 1, cr, cg, 8'($urandom), 1, "R5 R9 R11 sync pixel");
      cyc(0, 0, 0, 8'd0, 8'd0, 8'd0, 0, "");
      cyc(1, 0, 0, 8'd0, 8'd0, 8'd0, 0, "");
      row++;
      cyc(0, 0, 0, 8'd0, 8'd0, 8'd0, 0, "");
    end
  endtask

  task automatic de_frame();
    for (int i = 0; i < 20; i++)
      cyc(1'($urandom), 1'($urandom), 0, 8'd0, 8'd0, 8'd0, 0, "");
    fr++; row = 0;
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 2; p++)
        cyc(1'($urandom), 1'($urandom), 1, 8'($urandom), 8'($urandom), 8'($urandom),
            1, "R10 R11 DE-only pixel");
      row++;
      // gap after line 1 is exactly cfg_line_time: no new frame
      for (int i = 0; i < ((l == 1) ? 10 : 4); i++)
        cyc(1'($urandom), 1'($urandom), 0, 8'd0, 8'd0, 8'd0, 0, "");
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd1729);
    // R1: reset clears outputs even with busy inputs
    r_in = 8'hFF; g_in = 8'hA5; b_in = 8'h3C; hs_in = 1; vs_in = 1; de_in = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pixel", {r_out, g_out, b_out}, 0);
    check("R1 reset control", {hs_out, vs_out, de_out}, 0);

    // R3: bypass with random traffic
    cfg_enable = 0;
    do_reset();
    for (int i = 0; i < 200; i++)
      cyc(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
          8'($urandom), 1, "R3 bypass");

    // sync mode sweep of every code
    cfg_enable = 1; cfg_de_only = 0;
    cfg_hs_pol = 0; cfg_vs_pol = 1; cfg_de_pol = 0;
    do_reset();
    for (int c = 0; c < 256; c++) begin
      acc_on = 1; sum_r = 0; sum_g = 0; min_r = 255; max_r = 0;
      for (int f = 0; f < 8; f++) sync_frame(8'(c), 8'(255 - c));
      acc_on = 0;
      // R8: sum of 32 levels / 8 == 4*mean, compare within 1 (scaled by 8)
      begin
        int ref_r, ref_g, dr, dg;
        ref_r = (c > 252) ? 252 : c;
        ref_g = ((255 - c) > 252) ? 252 : 255 - c;
        dr = sum_r - 8 * ref_r; dg = sum_g - 8 * ref_g;
        check("R8 average red", (dr <= 8 && dr >= -8) ? 1 : 0, 1);
        check("R8 average green", (dg <= 8 && dg >= -8) ? 1 : 0, 1);
      end
      if (c == 0 || c == 255)
        check("R7 no flicker", max_r - min_r, 0);
    end

    // directed black and white pixels across one frame
    for (int f = 0; f < 2; f++) begin
      cyc(0, 1, 0, 8'd0, 8'd0, 8'd0, 0, ""); fr++; row = 0;
      cyc(0, 0, 1, 8'd0, 8'd0, 8'd0, 1, "R7 black pixel");
      cyc(0, 0, 1, 8'hFF, 8'hFF, 8'hFF, 1, "R7 white pixel");
      cyc(0, 0, 0, 8'd0, 8'd0, 8'd0, 0, "");
    end

    // DE-only mode, HS/VS noise
    cfg_de_only = 1; cfg_de_pol = 0; cfg_line_time = 16'd10;
    do_reset();
    for (int f = 0; f < 8; f++) de_frame();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule